// File: doc/BRIEF.md
# Dual-Mode Lane Crosspoint Router

This block connects four input data lanes to four output lanes. Each output lane carries the word of one chosen input lane, or all zeros when that output is turned off. The lane width is a parameter. Because one input may feed any number of outputs, the same source can be multicast to several outputs or broadcast to all four.

Two control sources are available, and the `split_mode` pin picks between them. In full mode, each output's 2-bit source index and its enable come from an external configuration bank (`cfg_sel`, `cfg_en`). In split mode, the router behaves as two separate 2x2 switches, driven directly by the address and data pins while chip select is asserted. Outputs 0 and 1 can only use inputs 0 and 1. Outputs 2 and 3 can only use inputs 2 and 3. When chip select is released in split mode, the last pin setting that was applied stays in force.

All pins are passed through a two-flop synchronizer before they are used. The lane data and the effective selection are both registered, so the routed word appears one clock after it is sampled. The effective per-output select and enable are also driven out so that a neighbour can see them.

Top module: `lane_xbar_dual`

## Requirements
- R1: With `split_mode` low (after synchronization), output i takes source index `cfg_sel[2i+1:2i]` and enable `cfg_en[i]`. Both show on `eff_sel`/`eff_en` one clock after they are sampled.
- R2: With `split_mode` high and `cs_n` low (both synchronized), `addr_pins[i]` enables output i (1 = on).
- R3: In split mode with `cs_n` low, `data_pins[i]` picks the source of output i. For outputs 0 and 1, 0 selects input 0 and 1 selects input 1. For outputs 2 and 3, 0 selects input 2 and 1 selects input 3. The effective index is 2*(i/2) + `data_pins[i]`.
- R4: In split mode, outputs 0 and 1 never show a source index of 2 or 3, and outputs 2 and 3 never show a source index of 0 or 1.
- R5: One input may drive several outputs at once, up to all four.
- R6: In split mode with `cs_n` high, the address and data pins are ignored, and the last split setting applied with `cs_n` low stays in effect.
- R7: A change of `split_mode` switches the control source as soon as the synchronized value changes. Pin values set up before the change into split mode take effect at that same edge, with no gap.
- R8: A disabled output lane drives all zeros.
- R9: `lane_out` carries the selected input word sampled one clock earlier. A pin change reaches `eff_sel`/`eff_en` on the third rising edge after it is applied, and never on an earlier edge.
- R10: During reset, `lane_out`, `eff_sel` and `eff_en` are zero, and the held split setting has all outputs disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_in | input | 4*LANE_W | Input lanes; lane j occupies bits [j*LANE_W +: LANE_W] |
| split_mode | input | 1 | 0 = full mode (bank control), 1 = split mode (pin control) |
| cs_n | input | 1 | Active-low chip select for the split-mode pins |
| addr_pins | input | 4 | Split mode: per-output enable |
| data_pins | input | 4 | Split mode: per-output source choice within its pair |
| cfg_sel | input | 8 | Full mode: 2-bit source index per output |
| cfg_en | input | 4 | Full mode: per-output enable |
| lane_out | output | 4*LANE_W | Routed output lanes |
| eff_sel | output | 8 | Effective source index per output |
| eff_en | output | 4 | Effective enable per output |

## Verification
The assertions assume that the configuration bank inputs stay stable from one sampling edge to the next. They also assume that the pins are asynchronous only within what the two-flop synchronizer can absorb, so the synchronized values are clean. The bench drives every input on the falling edge, which keeps the rising-edge samples well defined. It changes the pins in whole steps, and it checks split-mode behaviour only after the three edges of synchronizer and output latency have passed.

// File: rtl/lane_xbar_dual.sv
module lane_xbar_dual #(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4*LANE_W-1:0]   lane_in,
  input  logic                  split_mode,
  input  logic                  cs_n,
  input  logic [3:0]            addr_pins,
  input  logic [3:0]            data_pins,
  input  logic [7:0]            cfg_sel,
  input  logic [3:0]            cfg_en,
  output logic [4*LANE_W-1:0]   lane_out,
  output logic [7:0]            eff_sel,
  output logic [3:0]            eff_en
);
  localparam int LANES  = 4;
  localparam int SEL_W  = 2;
  localparam int PIN_W  = 2 + 2 * LANES;

  logic [PIN_W-1:0] pin_s1, pin_s2;
  logic             mode_s, cs_s;
  logic [3:0]       addr_s, data_s;
  logic [3:0]       held_en, held_d;
  logic [3:0]       split_en, split_d;
  logic [SEL_W-1:0] nxt_sel [LANES];
  logic [LANES-1:0] nxt_en;
  logic [LANE_W-1:0] lin [LANES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_s1 <= '0;
      pin_s2 <= '0;
    end else begin
      pin_s1 <= {split_mode, cs_n, addr_pins, data_pins};
      pin_s2 <= pin_s1;
    end

  assign mode_s = pin_s2[PIN_W-1];
  assign cs_s   = pin_s2[PIN_W-2];
  assign addr_s = pin_s2[7:4];
  assign data_s = pin_s2[3:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held_en <= '0;
      held_d  <= '0;
    end else if (mode_s && !cs_s) begin
      held_en <= addr_s;
      held_d  <= data_s;
    end

  assign split_en = cs_s ? held_en : addr_s;
  assign split_d  = cs_s ? held_d  : data_s;

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign lin[i] = lane_in[i*LANE_W +: LANE_W];
    assign nxt_sel[i] = mode_s ? {(i >= LANES/2) ? 1'b1 : 1'b0, split_d[i]}
                               : cfg_sel[i*SEL_W +: SEL_W];
    assign nxt_en[i]  = mode_s ? split_en[i] : cfg_en[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lane_out[i*LANE_W +: LANE_W] <= '0;
        eff_sel[i*SEL_W +: SEL_W]    <= '0;
        eff_en[i]                    <= 1'b0;
      end else begin
        lane_out[i*LANE_W +: LANE_W] <= nxt_en[i] ? lin[nxt_sel[i]] : '0;
        eff_sel[i*SEL_W +: SEL_W]    <= nxt_sel[i];
        eff_en[i]                    <= nxt_en[i];
      end

    AST_OFF_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !eff_en[i] |-> lane_out[i*LANE_W +: LANE_W] == '0); // R8
  end

  AST_FULL_FROM_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |=> (eff_sel == $past(cfg_sel)) && (eff_en == $past(cfg_en))); // R1

  AST_SPLIT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !cs_s) |=> eff_en == $past(addr_s)); // R2

  AST_SPLIT_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !cs_s) |=> {eff_sel[6], eff_sel[4], eff_sel[2], eff_sel[0]} == $past(data_s)); // R3

  AST_PAIR_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_s |=> (!eff_sel[1] && !eff_sel[3] && eff_sel[5] && eff_sel[7])); // R4

endmodule

// File: tb/lane_xbar_dual_test.sv
module lane_xbar_dual_test;
  localparam int W = 8;

  logic           clk = 0;
  logic           rst_n = 0;
  logic [4*W-1:0] lane_in = '0;
  logic           split_mode = 0;
  logic           cs_n = 1;
  logic [3:0]     addr_pins = '0;
  logic [3:0]     data_pins = '0;
  logic [7:0]     cfg_sel = '0;
  logic [3:0]     cfg_en = '0;
  logic [4*W-1:0] lane_out;
  logic [7:0]     eff_sel;
  logic [3:0]     eff_en;

  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R10";

  lane_xbar_dual #(.LANE_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .split_mode(split_mode),
    .cs_n(cs_n), .addr_pins(addr_pins), .data_pins(data_pins),
    .cfg_sel(cfg_sel), .cfg_en(cfg_en), .lane_out(lane_out),
    .eff_sel(eff_sel), .eff_en(eff_en)
  );

  always #5 clk = ~clk;

  always @(negedge clk) lane_in <= {$urandom, $urandom} ;

  // behavioural reference
  logic [9:0]     pq[$];
  logic [9:0]     use_p;
  logic [3:0]     h_en, h_d;
  logic [4*W-1:0] m_out;
  logic [7:0]     m_sel;
  logic [3:0]     m_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      pq = {10'd0, 10'd0};
      h_en = 0; h_d = 0; m_out = 0; m_sel = 0; m_en = 0;
    end else begin
      use_p = pq.pop_front();
      pq.push_back({split_mode, cs_n, addr_pins, data_pins});
      if (use_p[9]) begin
        if (!use_p[8]) begin h_en = use_p[7:4]; h_d = use_p[3:0]; end
        m_en = h_en;
        for (int i = 0; i < 4; i++) m_sel[2*i +: 2] = 2'((i < 2 ? 0 : 2) + int'(h_d[i]));
      end else begin
        m_en = cfg_en;
        m_sel = cfg_sel;
      end
      for (int i = 0; i < 4; i++)
        m_out[i*W +: W] = m_en[i] ? lane_in[int'(m_sel[2*i +: 2])*W +: W] : '0;
    end
    #1;
    vectors++;
    if (lane_out !== m_out || eff_sel !== m_sel || eff_en !== m_en) begin
      miscompares++;
      $display("FAIL %s per-clock: out=%h sel=%h en=%h expected out=%h sel=%h en=%h",
               tag, lane_out, eff_sel, eff_en, m_out, m_sel, m_en);
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R10 reset lane_out", lane_out, 0);
    chk("R10 reset eff_sel", {24'd0, eff_sel}, 0);
    chk("R10 reset eff_en", {28'd0, eff_en}, 0);
    rst_n = 1;

    tag = "R1";
    for (int k = 0; k < 40; k++) begin
      cfg_sel = 8'($urandom); cfg_en = 4'($urandom);
      step(1);
    end
    cfg_sel = 8'h1b; cfg_en = 4'hf;
    step(1);
    chk("R1 bank select", {24'd0, eff_sel}, 32'h1b);

    tag = "R5";
    for (int s = 0; s < 4; s++) begin
      cfg_sel = {4{2'(s)}}; cfg_en = 4'hf;
      step(4);
    end
    cfg_sel = 8'haa; step(1);
    chk("R5 broadcast select", {24'd0, eff_sel}, 32'haa);
    chk("R5 broadcast enable", {28'd0, eff_en}, 32'hf);

    tag = "R8";
    for (int k = 0; k < 20; k++) begin
      cfg_sel = 8'($urandom); cfg_en = 4'b0101; step(1);
    end
    chk("R8 disabled lane1 zero", {24'd0, lane_out[15:8]}, 0);
    chk("R8 disabled lane3 zero", {24'd0, lane_out[31:24]}, 0);

    tag = "R2 R3";
    addr_pins = 4'b1111; data_pins = 4'b0101; cs_n = 0; split_mode = 1;
    step(3);
    chk("R3 split select", {24'd0, eff_sel}, 32'b10_11_00_01);
    chk("R2 split enable", {28'd0, eff_en}, 32'hf);

    tag = "R9";
    data_pins = 4'b0000;
    step(2);
    chk("R9 not yet after two edges", {24'd0, eff_sel}, 32'b10_11_00_01);
    step(1);
    chk("R9 visible at third edge", {24'd0, eff_sel}, 32'b10_10_00_00);

    tag = "R4";
    for (int k = 0; k < 40; k++) begin
      addr_pins = 4'($urandom); data_pins = 4'($urandom); step(1);
    end

    tag = "R6";
    addr_pins = 4'b0011; data_pins = 4'b1111; step(3);
    cs_n = 1;
    for (int k = 0; k < 10; k++) begin
      addr_pins = 4'($urandom); data_pins = 4'($urandom); step(1);
    end
    chk("R6 held enable", {28'd0, eff_en}, 32'b0011);
    chk("R6 held select", {24'd0, eff_sel}, 32'b11_11_01_01);

    tag = "R7";
    cfg_sel = 8'he4; cfg_en = 4'hf; split_mode = 0;
    step(3);
    chk("R7 back to bank", {24'd0, eff_sel}, 32'he4);
    cs_n = 0; addr_pins = 4'b1010; data_pins = 4'b0000;
    step(3);
    chk("R7 pins ignored in full mode", {24'd0, eff_sel}, 32'he4);
    split_mode = 1;
    step(3);
    chk("R7 preset pins enable", {28'd0, eff_en}, 32'b1010);
    chk("R7 preset pins select", {24'd0, eff_sel}, 32'ha0);

    tag = "R7 mixed";
    for (int k = 0; k < 200; k++) begin
      if (k % 16 == 0) split_mode = 1'($urandom);
      cs_n = 1'($urandom); addr_pins = 4'($urandom); data_pins = 4'($urandom);
      cfg_sel = 8'($urandom); cfg_en = 4'($urandom);
      step(1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule